// File: doc/BRIEF.md
# Reloadable Down-Counting Tick Timer

This block divides a fast system clock into a slow periodic tick. A down counter starts from a value on the preload input and steps toward zero on each enabled clock. When it reaches zero, it reloads itself from the preload input on the next enabled edge. In that same cycle it raises a registered one-cycle strobe.

Each strobe also toggles a test-point output. That output is therefore a square wave at half the strobe rate. The live count is brought out for debug.

With preload N, the strobe repeats every N+1 enabled clocks. From a 50 MHz clock, a preload of 249,999 gives a 200 Hz display-scan tick and 4,999,999 gives a 10 Hz stopwatch tick. The clock enable may be tied high for free running, or it may be used to pause the timer.

Top module: `tick_timer`

## Requirements
- R1: While reset is high, and after it is released until the first enabled clock edge, zero_o and tp_o are 0 and count_o equals load_value.
- R2: On an enabled clock edge where count_o is nonzero, count_o decreases by exactly one and zero_o is 0 after that edge.
- R3: On an enabled clock edge where count_o is 0, count_o takes the value of load_value and zero_o is 1 after that edge.
- R4: With a constant preload N > 0 and the enable held high, zero_o is high for exactly one cycle out of every N+1, and the first pulse after reset follows the (N+1)-th enabled edge.
- R5: tp_o inverts on every edge that makes zero_o 1, and changes at no other time.
- R6: While ce is low, count_o (once the timer has seen an enabled edge), zero_o and tp_o hold their values.
- R7: With a preload of 0, zero_o is 1 after every enabled edge and tp_o toggles on every enabled edge.
- R8: Reset is asynchronous. Raising it clears zero_o and tp_o and shows load_value on count_o without waiting for a clock edge.
- R9: A change on load_value while the count is nonzero does not alter the running count. The new value is used only at the next reload.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Asynchronous active-high reset |
| ce | input | 1 | Clock enable; low pauses the timer |
| load_value | input | CNT_W (24) | Preload value; period is load_value+1 enabled clocks |
| zero_o | output | 1 | Registered one-cycle terminal strobe |
| tp_o | output | 1 | Test point; toggles on each strobe |
| count_o | output | CNT_W (24) | Current count, for debug |

## Verification
The in-line assertions check, on every cycle, the step rules:
- a decrement on a nonzero count;
- a reload together with a strobe on a zero count;
- holding while disabled;
- the test point moving only together with a strobe.

Only the bench's scenarios can show the things that span many cycles or happen between edges. These are the exact pulse spacing of N+1, the first-pulse latency after reset, and a preload change being ignored until the next reload. They also include the asynchronous reset acting between clock edges and the behaviour with a preload of 0.

// File: rtl/tick_pkg.sv
package tick_pkg;

    localparam int TICK_CNT_W = 24;

    // Whether the counter has consumed its first enabled edge since reset.
    typedef enum logic {
        TK_IDLE = 1'b0,
        TK_RUN  = 1'b1
    } tick_mode_e;

    // Registered strobe outputs.
    typedef struct packed {
        logic zero;
        logic tp;
    } tick_out_t;

endpackage

// File: rtl/tick_down_counter.sv
module tick_down_counter
    import tick_pkg::*;
#(
    parameter int CNT_W = TICK_CNT_W
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             ce,
    input  logic [CNT_W-1:0] load_i,
    output logic [CNT_W-1:0] count_o,
    output logic             hit_o,
    output logic             armed_o
);

    localparam logic [CNT_W-1:0] ONE = CNT_W'(1);

    tick_mode_e       mode_q;
    logic [CNT_W-1:0] cnt_q;
    logic [CNT_W-1:0] eff;

    // Before the first enabled edge the count reflects the preload port.
    always_comb begin
        eff   = (mode_q == TK_RUN) ? cnt_q : load_i;
        hit_o = (eff == '0);
    end

    always_ff @(posedge clk or posedge rst) begin
        if (rst) begin
            cnt_q  <= '0;
            mode_q <= TK_IDLE;
        end else if (ce) begin
            mode_q <= TK_RUN;
            cnt_q  <= hit_o ? load_i : (eff - ONE);
        end
    end

    assign count_o = eff;
    assign armed_o = (mode_q == TK_RUN);

    // R6: a running count is frozen while the enable is low
    a_r6_count_hold: assert property (@(posedge clk) disable iff (rst)
        (!ce && armed_o) |=> $stable(count_o));

endmodule

// File: rtl/tick_strobe_gen.sv
module tick_strobe_gen
    import tick_pkg::*;
(
    input  logic clk,
    input  logic rst,
    input  logic ce,
    input  logic hit_i,
    output logic zero_o,
    output logic tp_o
);

    tick_out_t out_q;

    always_ff @(posedge clk or posedge rst) begin
        if (rst) begin
            out_q <= '0;
        end else if (ce) begin
            out_q.zero <= hit_i;
            if (hit_i) begin
                out_q.tp <= ~out_q.tp;
            end
        end
    end

    assign zero_o = out_q.zero;
    assign tp_o   = out_q.tp;

    // R5: the test point moves only on an edge that raises the strobe
    a_r5_tp_with_zero: assert property (@(posedge clk) disable iff (rst)
        !$stable(tp_o) |-> zero_o);

    // R6: strobe outputs hold while disabled
    a_r6_strobe_hold: assert property (@(posedge clk) disable iff (rst)
        !ce |=> ($stable(zero_o) && $stable(tp_o)));

endmodule

// File: rtl/tick_timer.sv
module tick_timer
    import tick_pkg::*;
#(
    parameter int CNT_W = TICK_CNT_W
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             ce,
    input  logic [CNT_W-1:0] load_value,
    output logic             zero_o,
    output logic             tp_o,
    output logic [CNT_W-1:0] count_o
);

    logic hit;
    logic armed;

    tick_down_counter #(.CNT_W(CNT_W)) u_cnt (
        .clk     (clk),
        .rst     (rst),
        .ce      (ce),
        .load_i  (load_value),
        .count_o (count_o),
        .hit_o   (hit),
        .armed_o (armed)
    );

    tick_strobe_gen u_strobe (
        .clk    (clk),
        .rst    (rst),
        .ce     (ce),
        .hit_i  (hit),
        .zero_o (zero_o),
        .tp_o   (tp_o)
    );

    // R2: nonzero count steps down by one with no strobe
    a_r2_decrement: assert property (@(posedge clk) disable iff (rst)
        (ce && count_o != '0) |=> (!zero_o && count_o == $past(count_o) - CNT_W'(1)));

    // R3: zero count reloads from the preload port and strobes
    a_r3_reload: assert property (@(posedge clk) disable iff (rst)
        (ce && count_o == '0) |=> (zero_o && count_o == $past(load_value)));

    // R7: a zero preload strobes on every enabled edge
    a_r7_zero_preload: assert property (@(posedge clk) disable iff (rst)
        (ce && load_value == '0 && count_o == '0) |=> zero_o);

endmodule

// File: tb/tb_tick_timer.sv
module tb_tick_timer;

    localparam int W = 24;
    localparam int NV = 21;

    logic         clk = 1'b0;
    logic         rst;
    logic         ce;
    logic [W-1:0] load_value;
    logic         zero_o;
    logic         tp_o;
    logic [W-1:0] count_o;

    int n_run  = 0;
    int n_fail = 0;
    bit done   = 1'b0;

    always #2.5 clk = ~clk;

    tick_timer #(.CNT_W(W)) dut (
        .clk        (clk),
        .rst        (rst),
        .ce         (ce),
        .load_value (load_value),
        .zero_o     (zero_o),
        .tp_o       (tp_o),
        .count_o    (count_o)
    );

    // {ce, load, expected count, expected zero, expected tp} after each edge
    localparam logic [50:0] VEC [NV] = '{
        {1'b1, 24'd3, 24'd2, 1'b0, 1'b0},
        {1'b1, 24'd3, 24'd1, 1'b0, 1'b0},
        {1'b1, 24'd3, 24'd0, 1'b0, 1'b0},
        {1'b1, 24'd3, 24'd3, 1'b1, 1'b1},
        {1'b1, 24'd3, 24'd2, 1'b0, 1'b1},
        {1'b0, 24'd3, 24'd2, 1'b0, 1'b1},
        {1'b0, 24'd3, 24'd2, 1'b0, 1'b1},
        {1'b1, 24'd5, 24'd1, 1'b0, 1'b1},
        {1'b1, 24'd5, 24'd0, 1'b0, 1'b1},
        {1'b1, 24'd5, 24'd5, 1'b1, 1'b0},
        {1'b0, 24'd5, 24'd5, 1'b1, 1'b0},
        {1'b1, 24'd5, 24'd4, 1'b0, 1'b0},
        {1'b1, 24'd5, 24'd3, 1'b0, 1'b0},
        {1'b1, 24'd0, 24'd2, 1'b0, 1'b0},
        {1'b1, 24'd0, 24'd1, 1'b0, 1'b0},
        {1'b1, 24'd0, 24'd0, 1'b0, 1'b0},
        {1'b1, 24'd0, 24'd0, 1'b1, 1'b1},
        {1'b1, 24'd0, 24'd0, 1'b1, 1'b0},
        {1'b1, 24'd0, 24'd0, 1'b1, 1'b1},
        {1'b1, 24'd2, 24'd2, 1'b1, 1'b0},
        {1'b1, 24'd2, 24'd1, 1'b0, 1'b0}
    };

    function automatic string vec_tag(int i);
        if (i == 5 || i == 6 || i == 10) return "R6";
        if (i == 7 || i == 8)            return "R9";
        if (i >= 15 && i <= 18)          return "R7";
        if (i == 3 || i == 9 || i == 19) return "R3/R5";
        return "R2";
    endfunction

    task automatic chk(string tag, logic [W-1:0] ec, logic ez, logic et);
        n_run++;
        if (count_o !== ec || zero_o !== ez || tp_o !== et) begin
            n_fail++;
            $display("FAIL %s: count=%0d zero=%b tp=%b expected count=%0d zero=%b tp=%b",
                     tag, count_o, zero_o, tp_o, ec, ez, et);
        end
    endtask

    task automatic chk_int(string tag, int act, int exp);
        n_run++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s: actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    task automatic report();
        $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    endtask

    initial begin
        #200000;
        if (!done) begin
            n_run++;
            n_fail++;
            $display("FAIL watchdog: actual=timeout expected=completion");
            report();
        end
    end

    initial begin
        int gap;
        int first;
        rst = 1'b1; ce = 1'b0; load_value = 24'd3;
        repeat (2) @(posedge clk);
        #1;
        chk("R1 in reset", 24'd3, 1'b0, 1'b0);
        rst = 1'b0;
        @(posedge clk); #1;
        chk("R1 idle after release", 24'd3, 1'b0, 1'b0);
        load_value = 24'd9; #1;
        chk("R1 follows preload before first enable", 24'd9, 1'b0, 1'b0);
        load_value = 24'd3;

        // table walk
        for (int i = 0; i < NV; i++) begin
            ce = VEC[i][50];
            load_value = VEC[i][49:26];
            @(posedge clk); #1;
            chk(vec_tag(i), VEC[i][25:2], VEC[i][1], VEC[i][0]);
        end

        // reach zero=1,tp=1 then reset between edges (count 1 -> 0 -> reload)
        load_value = 24'd0;
        @(posedge clk); #1;
        @(posedge clk); #1;
        chk("R7 pre-reset state", 24'd0, 1'b1, 1'b1);
        load_value = 24'd7;
        #0.5 rst = 1'b1;
        #0.5;
        chk("R8 async reset between edges", 24'd7, 1'b0, 1'b0);
        @(negedge clk);
        rst = 1'b0;
        ce = 1'b1;

        // period and first-pulse latency with N=7
        first = 0;
        for (int k = 1; k <= 40 && first == 0; k++) begin
            @(posedge clk); #1;
            if (zero_o) first = k;
        end
        chk_int("R4 first pulse latency", first, 8);
        gap = 0;
        for (int k = 1; k <= 40; k++) begin
            @(posedge clk); #1;
            if (zero_o) begin gap = k; break; end
        end
        chk_int("R4 pulse spacing", gap, 8);
        @(posedge clk); #1;
        chk("R4 single-cycle pulse", 24'd6, 1'b0, 1'b0);

        done = 1'b1;
        report();
    end

endmodule